// File: doc/BRIEF.md
# Multichannel Event Counter with Wrap Interrupt Queue

This block counts pulse events arriving on a set of independent input lines. Every channel owns a double-width count split into a low word and a high word. The counts live in a small storage array, not in one counter per channel, and a single read-modify-write path serves one channel per clock. Input lines are first brought into the clock domain and reduced to one-cycle rising-edge events. Each event is then held pending until a round-robin arbiter grants its channel.

Channels picked by a parameter mask work as up/down position counters for an incremental shaft encoder. They take an up-step line, a down-step line and a reference-position line that returns the count to zero. Whenever a low word wraps, upward or downward, the channel number and the direction are pushed into a small interrupt queue. A host reads any channel's full count with a strobe and an index, and retires queued interrupts with an acknowledge.

Top module: `evc_top`

## Requirements
- R1: After reset every channel's count reads 0 (low and high word) and `irq` is low.
- R2: On a counting channel (mask bit 0) each rising edge of `evt_in[i]` adds one to the count. `dn_in[i]` and `ref_in[i]` have no effect on that channel.
- R3: When the low word wraps from all-ones to zero, the high word increments. When a decrement takes the low word from zero to all-ones, the high word decrements.
- R4: On an encoder channel (mask bit 1) a serviced `evt_in` edge adds one and a serviced `dn_in` edge subtracts one. If both are serviced together, the count is unchanged.
- R5: A serviced `ref_in` edge on an encoder channel sets both words to 0 and raises no interrupt. Steps serviced in that same cycle are discarded.
- R6: Every low-word wrap pushes an entry with the channel number and a direction flag (`irq_dn` 0 = upward wrap, 1 = downward wrap). `irq` is high while the queue holds entries, and `irq_ch`/`irq_dn` show the oldest entry.
- R7: `irq_ack` while `irq` is high removes the oldest entry. `irq_ack` while the queue is empty has no effect.
- R8: When the queue already holds IRQ_DEPTH entries, a new wrap entry is dropped and the queued entries stay unchanged.
- R9: Events arriving on all channels in the same cycle are all counted. Pending channels are served one per cycle in round-robin order.
- R10: `rd_stb` with `rd_ch` makes `rd_vld` high in the next cycle. In that cycle `rd_lo` and `rd_hi` hold both words of the count as stored in the cycle of the strobe.
- R11: An input held high for several cycles counts as a single event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | NCH | Event line per channel (up step on encoder channels) |
| dn_in | input | NCH | Down-step line, used on encoder channels only |
| ref_in | input | NCH | Reference-position line, used on encoder channels only |
| rd_stb | input | 1 | Host read strobe |
| rd_ch | input | CH_W | Channel index for the host read |
| rd_vld | output | 1 | Read data valid |
| rd_lo | output | WORD_W | Low word of the channel that was read |
| rd_hi | output | WORD_W | High word of the channel that was read |
| irq | output | 1 | Interrupt request, high while the queue is non-empty |
| irq_ch | output | CH_W | Channel number of the oldest queued wrap |
| irq_dn | output | 1 | Direction of the oldest queued wrap (1 = downward) |
| irq_ack | input | 1 | Host acknowledge, removes the oldest entry |

## Verification
The main counting path is driven with event masks of several kinds. An all-channel burst separates a lossless arbiter from one that drops simultaneous requests. Sparse and alternating masks show whether each count moves independently of its neighbours. Masks that hit counting channels with down and reference pulses show that a non-encoder channel ignores those lines. On encoder channels, paired up/down steps tell the cancelling rule apart from priority to one direction, and reference-with-step tells a zeroing reference apart from a merged update. Alternating down and up steps on one channel around zero walk both wrap directions and fill the queue past its depth, which exposes the order of queued entries and the drop-when-full rule.

// File: rtl/evc_pkg.sv
package evc_pkg;
   // Kind of update applied to the serviced channel in one cycle
   typedef enum logic [1:0] {
      UPD_HOLD  = 2'd0,
      UPD_INC   = 2'd1,
      UPD_DEC   = 2'd2,
      UPD_CLEAR = 2'd3
   } upd_e;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/evc_edge_sync.sv
module evc_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES:0] sh_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("evc_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], din};
   end

   assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/evc_rr_arb.sv
module evc_rr_arb #(
   parameter int unsigned N   = 8,
   parameter int unsigned IXW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   req,
   output logic [N-1:0]   gnt,
   output logic [IXW-1:0] gnt_idx,
   output logic           gnt_vld
);
   logic [IXW-1:0] ptr_q;

   always_comb begin
      gnt     = '0;
      gnt_idx = '0;
      gnt_vld = 1'b0;
      for (int k = 0; k < int'(N); k++) begin
         int cand;
         cand = (int'(ptr_q) + k) % int'(N);
         if (!gnt_vld && req[cand]) begin
            gnt_vld   = 1'b1;
            gnt_idx   = IXW'(cand);
            gnt[cand] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr_q <= '0;
      else if (gnt_vld) begin
         if (int'(gnt_idx) == int'(N) - 1) ptr_q <= '0;
         else                              ptr_q <= gnt_idx + 1'b1;
      end
   end
endmodule

// File: rtl/evc_count_mem.sv
module evc_count_mem #(
   parameter int unsigned N   = 8,
   parameter int unsigned W   = 16,
   parameter int unsigned IXW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   // update port: combinational read, write at the edge
   input  logic [IXW-1:0] up_idx,
   output logic [W-1:0]   up_lo,
   output logic [W-1:0]   up_hi,
   input  logic           wr_en,
   input  logic [W-1:0]   wr_lo,
   input  logic [W-1:0]   wr_hi,
   // host port: registered, both words from one snapshot
   input  logic           rd_stb,
   input  logic [IXW-1:0] rd_idx,
   output logic           rd_vld,
   output logic [W-1:0]   rd_lo,
   output logic [W-1:0]   rd_hi
);
   logic [W-1:0] lo_q [N];
   logic [W-1:0] hi_q [N];

   assign up_lo = lo_q[up_idx];
   assign up_hi = hi_q[up_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(N); i++) begin
            lo_q[i] <= '0;
            hi_q[i] <= '0;
         end
      end else if (wr_en) begin
         lo_q[up_idx] <= wr_lo;
         hi_q[up_idx] <= wr_hi;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_vld <= 1'b0;
         rd_lo  <= '0;
         rd_hi  <= '0;
      end else begin
         rd_vld <= rd_stb;
         if (rd_stb) begin
            rd_lo <= lo_q[rd_idx];
            rd_hi <= hi_q[rd_idx];
         end
      end
   end
endmodule

// File: rtl/evc_irq_fifo.sv
module evc_irq_fifo #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned DW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          not_empty
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad
         $error("evc_irq_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DW-1:0] slot_q [DEPTH];
   logic [PW:0]   wp_q, rp_q;
   logic          full, do_pop, do_push;

   assign not_empty = (wp_q != rp_q);
   assign full      = (wp_q[PW] != rp_q[PW]) && (wp_q[PW-1:0] == rp_q[PW-1:0]);
   assign do_pop    = pop & not_empty;
   assign do_push   = push & (~full | do_pop);
   assign head      = slot_q[rp_q[PW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
         for (int i = 0; i < int'(DEPTH); i++) slot_q[i] <= '0;
      end else begin
         if (do_push) begin
            slot_q[wp_q[PW-1:0]] <= push_data;
            wp_q <= wp_q + 1'b1;
         end
         if (do_pop) rp_q <= rp_q + 1'b1;
      end
   end
endmodule

// File: rtl/evc_top.sv
module evc_top #(
   parameter int unsigned          NCH       = 8,
   parameter int unsigned          WORD_W    = 16,
   parameter int unsigned          IRQ_DEPTH = 4,
   parameter int unsigned          SYNC_STG  = 2,
   parameter logic [NCH-1:0]       ENC_MASK  = 'hC0,
   localparam int unsigned         CH_W      = evc_pkg::idx_w(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    evt_in,
   input  logic [NCH-1:0]    dn_in,
   input  logic [NCH-1:0]    ref_in,
   input  logic              rd_stb,
   input  logic [CH_W-1:0]   rd_ch,
   output logic              rd_vld,
   output logic [WORD_W-1:0] rd_lo,
   output logic [WORD_W-1:0] rd_hi,
   output logic              irq,
   output logic [CH_W-1:0]   irq_ch,
   output logic              irq_dn,
   input  logic              irq_ack
);
   import evc_pkg::*;

   localparam int unsigned QW = CH_W + 1;

   generate
      if (NCH < 2)    begin : g_bad_n $error("evc_top: NCH must be at least 2"); end
      if (WORD_W < 2) begin : g_bad_w $error("evc_top: WORD_W must be at least 2"); end
   endgenerate

   logic [NCH-1:0] up_e, dn_e, ref_e;
   logic [NCH-1:0] pend_up, pend_dn, pend_ref, req, gnt;
   logic [CH_W-1:0] gnt_idx;
   logic gnt_vld;

   // per-channel capture: the mask picks the counting or encoder variant
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      evc_edge_sync #(.STAGES(SYNC_STG)) u_up (
         .clk(clk), .rst_n(rst_n), .din(evt_in[i]), .rise(up_e[i]));
      if (ENC_MASK[i]) begin : g_enc
         evc_edge_sync #(.STAGES(SYNC_STG)) u_dn (
            .clk(clk), .rst_n(rst_n), .din(dn_in[i]), .rise(dn_e[i]));
         evc_edge_sync #(.STAGES(SYNC_STG)) u_ref (
            .clk(clk), .rst_n(rst_n), .din(ref_in[i]), .rise(ref_e[i]));
      end else begin : g_cnt
         logic unused_enc_pins;
         assign unused_enc_pins = dn_in[i] ^ ref_in[i];
         assign dn_e[i]  = 1'b0;
         assign ref_e[i] = 1'b0;
      end
   end

   // pending flags: clear on grant, a fresh edge always wins over the clear
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_up  <= '0;
         pend_dn  <= '0;
         pend_ref <= '0;
      end else begin
         pend_up  <= (pend_up  & ~gnt) | up_e;
         pend_dn  <= (pend_dn  & ~gnt) | dn_e;
         pend_ref <= (pend_ref & ~gnt) | ref_e;
      end
   end

   assign req = pend_up | pend_dn | pend_ref;

   evc_rr_arb #(.N(NCH), .IXW(CH_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req),
      .gnt(gnt), .gnt_idx(gnt_idx), .gnt_vld(gnt_vld));

   // read-modify-write of the granted channel
   logic [WORD_W-1:0] cur_lo, cur_hi, nxt_lo, nxt_hi;
   upd_e              upd;
   logic              wrap_push, wrap_dn;

   always_comb begin
      if (pend_ref[gnt_idx])                           upd = UPD_CLEAR;
      else if (pend_up[gnt_idx] && !pend_dn[gnt_idx])  upd = UPD_INC;
      else if (pend_dn[gnt_idx] && !pend_up[gnt_idx])  upd = UPD_DEC;
      else                                             upd = UPD_HOLD;
   end

   always_comb begin
      nxt_lo    = cur_lo;
      nxt_hi    = cur_hi;
      wrap_push = 1'b0;
      wrap_dn   = 1'b0;
      unique case (upd)
         UPD_CLEAR: begin
            nxt_lo = '0;
            nxt_hi = '0;
         end
         UPD_INC: begin
            nxt_lo = cur_lo + 1'b1;
            if (&cur_lo) begin
               nxt_hi    = cur_hi + 1'b1;
               wrap_push = gnt_vld;
            end
         end
         UPD_DEC: begin
            nxt_lo = cur_lo - 1'b1;
            if (cur_lo == '0) begin
               nxt_hi    = cur_hi - 1'b1;
               wrap_push = gnt_vld;
               wrap_dn   = 1'b1;
            end
         end
         default: ;
      endcase
   end

   evc_count_mem #(.N(NCH), .W(WORD_W), .IXW(CH_W)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .up_idx(gnt_idx), .up_lo(cur_lo), .up_hi(cur_hi),
      .wr_en(gnt_vld), .wr_lo(nxt_lo), .wr_hi(nxt_hi),
      .rd_stb(rd_stb), .rd_idx(rd_ch),
      .rd_vld(rd_vld), .rd_lo(rd_lo), .rd_hi(rd_hi));

   logic [QW-1:0] q_head;

   evc_irq_fifo #(.DEPTH(IRQ_DEPTH), .DW(QW)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .push(wrap_push), .push_data({wrap_dn, gnt_idx}),
      .pop(irq_ack), .head(q_head), .not_empty(irq));

   assign irq_ch = q_head[CH_W-1:0];
   assign irq_dn = q_head[QW-1];
endmodule

// File: rtl/evc_chk.sv
module evc_chk #(
   parameter int unsigned NCH  = 8,
   parameter int unsigned CH_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NCH-1:0]  req,
   input logic [NCH-1:0]  gnt,
   input logic            wrap_push,
   input logic            rd_stb,
   input logic            rd_vld,
   input logic            irq,
   input logic            irq_ack,
   input logic [CH_W-1:0] irq_ch,
   input logic            irq_dn
);
   // R9
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   // R9
   grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
   // R9
   work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|gnt));
   // R9
   no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(req & ~gnt)) |=> ((($past(req) & ~$past(gnt)) & ~req) == '0));
   // R10
   read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> rd_vld);
   // R10
   read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> !rd_vld);
   // R6
   irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_push && !irq) |=> irq);
   // R6
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> (irq && $stable(irq_ch) && $stable(irq_dn)));
   // R7
   irq_idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !wrap_push) |=> !irq);
endmodule

bind evc_top evc_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .wrap_push(wrap_push),
   .rd_stb(rd_stb), .rd_vld(rd_vld), .irq(irq), .irq_ack(irq_ack),
   .irq_ch(irq_ch), .irq_dn(irq_dn));

// File: tb/evc_top_test.sv
module evc_top_test;
   localparam int unsigned NCH = 8;
   localparam int unsigned W   = 16;
   localparam logic [NCH-1:0] ENC = 8'hC0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] evt_in = '0, dn_in = '0, ref_in = '0;
   logic rd_stb = 1'b0;
   logic [2:0] rd_ch = '0;
   logic rd_vld, irq, irq_dn, irq_ack = 1'b0;
   logic [W-1:0] rd_lo, rd_hi;
   logic [2:0] irq_ch;

   always #4 clk = ~clk;

   evc_top #(.NCH(NCH), .WORD_W(W), .IRQ_DEPTH(4), .ENC_MASK(ENC)) uut (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .dn_in(dn_in), .ref_in(ref_in),
      .rd_stb(rd_stb), .rd_ch(rd_ch), .rd_vld(rd_vld), .rd_lo(rd_lo), .rd_hi(rd_hi),
      .irq(irq), .irq_ch(irq_ch), .irq_dn(irq_dn), .irq_ack(irq_ack));

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [31:0] model [NCH];

   // stimulus table: {up mask, down mask, reference mask}
   localparam int NV = 10;
   localparam logic [23:0] VEC [NV] = '{
      {8'hFF, 8'h00, 8'h00},
      {8'h01, 8'hFF, 8'hFF},
      {8'hC0, 8'h00, 8'h00},
      {8'h00, 8'h40, 8'h00},
      {8'h80, 8'h80, 8'h00},
      {8'h0F, 8'h00, 8'h00},
      {8'hAA, 8'h00, 8'h00},
      {8'hC0, 8'h00, 8'hC0},
      {8'h55, 8'h3F, 8'h00},
      {8'hFF, 8'h00, 8'h00}
   };
   localparam string VREQ [NV] = '{"R9", "R2", "R4", "R4", "R4",
                                   "R11", "R2", "R5", "R2", "R9"};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse(input logic [NCH-1:0] u, input logic [NCH-1:0] d, input logic [NCH-1:0] r);
      @(negedge clk);
      evt_in = u; dn_in = d; ref_in = r;
      repeat (3) @(negedge clk);
      evt_in = '0; dn_in = '0; ref_in = '0;
      repeat (24) @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
         if (ENC[c]) begin
            if (r[c])                model[c] = 32'd0;
            else if (u[c] && !d[c])  model[c] = model[c] + 32'd1;
            else if (d[c] && !u[c])  model[c] = model[c] - 32'd1;
         end else if (u[c]) begin
            model[c] = model[c] + 32'd1;
         end
      end
   endtask

   task automatic read_ch(input int c, output logic [31:0] val);
      @(negedge clk);
      rd_stb = 1'b1; rd_ch = 3'(c);
      @(negedge clk);
      rd_stb = 1'b0;
      check("R10", {31'd0, rd_vld}, 32'd1);
      val = {rd_hi, rd_lo};
   endtask

   task automatic ack();
      @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      for (int c = 0; c < NCH; c++) model[c] = 32'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", {31'd0, irq}, 32'd0);
      for (int c = 0; c < NCH; c++) begin
         read_ch(c, v);
         check("R1", v, 32'd0);
      end

      // table walk
      for (int t = 0; t < NV; t++) begin
         pulse(VEC[t][23:16], VEC[t][15:8], VEC[t][7:0]);
         check(VREQ[t], {31'd0, irq}, 32'd0);
         for (int c = 0; c < NCH; c++) begin
            read_ch(c, v);
            check(VREQ[t], v, model[c]);
         end
      end

      // directed: zero encoders, then wrap downward on channel 7
      pulse(8'h00, 8'h00, 8'hC0);
      pulse(8'h00, 8'h80, 8'h00);
      check("R6", {31'd0, irq}, 32'd1);
      check("R6", {29'd0, irq_ch}, 32'd7);
      check("R6", {31'd0, irq_dn}, 32'd1);
      read_ch(7, v);
      check("R3", v, 32'hFFFF_FFFF);
      ack();
      check("R7", {31'd0, irq}, 32'd0);
      ack();
      check("R7", {31'd0, irq}, 32'd0);
      read_ch(7, v);
      check("R7", v, 32'hFFFF_FFFF);

      // five wraps into a four-deep queue: the fifth is dropped
      pulse(8'h80, 8'h00, 8'h00);
      read_ch(7, v);
      check("R3", v, 32'd0);
      pulse(8'h00, 8'h80, 8'h00);
      pulse(8'h80, 8'h00, 8'h00);
      pulse(8'h00, 8'h80, 8'h00);
      pulse(8'h80, 8'h00, 8'h00);
      for (int k = 0; k < 4; k++) begin
         check("R8", {31'd0, irq}, 32'd1);
         check("R8", {29'd0, irq_ch}, 32'd7);
         check("R8", {31'd0, irq_dn}, (k % 2 == 0) ? 32'd0 : 32'd1);
         ack();
      end
      check("R8", {31'd0, irq}, 32'd0);
      read_ch(7, v);
      check("R3", v, 32'd0);
      read_ch(6, v);
      check("R5", v, 32'd0);
      finish_run();
   end
endmodule